// File: doc/BRIEF.md
# Baseline Multistage Switching Fabric

This block connects N source ports to N destination ports through log2(N) columns of two-input, two-output switching elements. Between adjacent columns the lines are regrouped by an inverse-shuffle inside each sub-block, so column 0 acts as one N-wide block, column 1 as two half-width blocks, and so on down to single elements. Every path crosses exactly log2(N) elements, and the fabric holds no storage, so a word and its valid flag reach the selected output with the same fixed delay from any source.

Each element takes one of four settings: pass straight, cross over, copy its upper input to both outputs, or copy its lower input to both outputs. The settings sit in a configuration register that changes only on a clock edge. Software can load a raw settings vector, or present a set of source-to-destination route requests. A route planner then steers each route by the destination address, most significant bit first, and merges the element settings the routes need. Routes that share one source become a broadcast. An element that two routes would drive from different inputs onto one output is reported as a conflict and keeps its old setting.

Top module: `baseline_fabric`

## Requirements
- R1: After reset every element is straight (code 00) and `conflict` is low, so source i appears at output bitrev(i), where bitrev reverses the log2(N) index bits.
- R2: Element k = stage*(N/2)+position uses bits [2k+1:2k] of the settings. Its upper input and output sit on lines 2·position and its lower ones on line 2·position+1. Code 00 is straight, 01 cross, 10 upper input to both outputs, and 11 lower input to both outputs. With all elements at 10 every output carries source 0, and with all at 11 every output carries source N-1.
- R3: `cfgLoad` at a clock edge writes `cfgIn` to the settings register and clears `conflict`. It takes priority over a simultaneous `routeApply`.
- R4: Without `cfgLoad` or `routeApply` the settings and `conflict` stay unchanged, whatever `cfgIn` does.
- R5: After a `routeApply` with one enabled slot (src, dst), output dst carries source src and `conflict` is low. A destination bit of 0 selects an element's upper output, taken most significant bit at stage 0.
- R6: Enabled slots that share a source and name different destinations deliver that source to every named destination without a conflict.
- R7: If two enabled routes would drive one element output from different inputs, `conflict` goes high after the edge and that element keeps its previous setting. Elements used without a clash take their merged setting.
- R8: Each `routeApply` rewrites `conflict`, so a clean apply after a conflicting one clears it.
- R9: The valid flag travels with its word. An output's valid equals the valid of the source routed to it.
- R10: The path from input to output is combinational. A data change at a source reaches its output within the same cycle, with no clock edge.
- R11: The routes i→bitrev(i) for all i set every element to straight. The routes i→~bitrev(i) set every element to cross.
- R12: Elements that no enabled route touches keep their setting. An apply with no enabled slot leaves the settings unchanged and clears `conflict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load raw settings vector |
| cfgIn | input | 2·(N/2)·log2N | Raw settings, 2 bits per element |
| routeApply | input | 1 | Apply the enabled route requests |
| reqEn | input | SLOTS | Enable per request slot |
| reqSrc | input | SLOTS·log2N | Source index per slot |
| reqDst | input | SLOTS·log2N | Destination index per slot |
| inValid | input | N | Valid flag per source |
| inData | input | N·32 | Data word per source |
| outValid | output | N | Valid flag per destination |
| outData | output | N·32 | Data word per destination |
| cfgOut | output | 2·(N/2)·log2N | Current settings register |
| conflict | output | 1 | Last route apply had a clash |

## Verification
The assertions check the following on every cycle: the settings hold between strobes, a raw load lands exactly, the conflict flag is quiet while no strobe is present, a broadcasting last-stage element drives equal outputs, and the outputs carry no valid when no source is valid. Only the bench scenarios show the following: routes steered by the destination bits actually reach the named output, shared sources merge into broadcasts, a clash leaves the clashing element untouched while the other elements update, and whole permutations produce uniform straight or cross settings.

// File: rtl/baseline_fabric_pkg.sv
package baseline_fabric_pkg;

  typedef enum logic [1:0] {
    SW_STRAIGHT = 2'b00,
    SW_CROSS    = 2'b01,
    SW_BCAST_UP = 2'b10,
    SW_BCAST_LO = 2'b11
  } swState_e;

  // strobes from the route planner to the datapath
  typedef struct packed {
    logic cfgWrite;
    logic rawLoad;
  } cfgStrobe_t;

endpackage

// File: rtl/baseline_sw2.sv
module baseline_sw2 #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]      state,
  input  logic [DATA_W:0] upIn,
  input  logic [DATA_W:0] loIn,
  output logic [DATA_W:0] upOut,
  output logic [DATA_W:0] loOut
);
  import baseline_fabric_pkg::*;

  always_comb begin
    case (state)
      SW_STRAIGHT: begin upOut = upIn; loOut = loIn; end
      SW_CROSS:    begin upOut = loIn; loOut = upIn; end
      SW_BCAST_UP: begin upOut = upIn; loOut = upIn; end
      default:     begin upOut = loIn; loOut = loIn; end
    endcase
  end
endmodule

// File: rtl/baseline_route_ctl.sv
module baseline_route_ctl
  import baseline_fabric_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int N_SLOTS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgLoad,
  input  logic [CFG_W-1:0]             cfgIn,
  input  logic                         routeApply,
  input  logic [N_SLOTS-1:0]           reqEn,
  input  logic [N_SLOTS*LOG_N-1:0]     reqSrc,
  input  logic [N_SLOTS*LOG_N-1:0]     reqDst,
  input  logic [CFG_W-1:0]             curCfg,
  output cfgStrobe_t                   strobe,
  output logic [CFG_W-1:0]             nextCfg,
  output logic                         conflict
);
  localparam int LOG_N  = $clog2(N_PORTS);
  localparam int HALF   = N_PORTS / 2;
  localparam int N_ELEM = HALF * LOG_N;
  localparam int CFG_W  = 2 * N_ELEM;
  localparam int EDGE_W = 4 * N_ELEM;

  // Edge bit (element*4 + inPort*2 + outPort) for every element a route crosses.
  function automatic logic [EDGE_W-1:0] routeEdges(input logic [LOG_N-1:0] src,
                                                   input logic [LOG_N-1:0] dst);
    logic [EDGE_W-1:0] e;
    int line, el, ip, op, o, blk, base, q;
    e    = '0;
    line = int'(src);
    for (int s = 0; s < LOG_N; s++) begin
      el = line / 2;
      ip = line % 2;
      op = int'(dst[LOG_N-1-s]);
      e[(s*HALF + el)*4 + ip*2 + op] = 1'b1;
      o    = el*2 + op;
      blk  = N_PORTS >> s;
      base = (o / blk) * blk;
      q    = o % blk;
      line = base + q/2 + (q%2)*(blk/2);
    end
    return e;
  endfunction

  logic [EDGE_W-1:0] usage;
  logic [CFG_W-1:0]  routeCfg;
  logic [N_ELEM-1:0] elemClash;
  logic              anyClash;
  logic              conflictQ;

  always_comb begin
    usage = '0;
    for (int k = 0; k < N_SLOTS; k++) begin
      if (reqEn[k]) usage |= routeEdges(reqSrc[k*LOG_N +: LOG_N], reqDst[k*LOG_N +: LOG_N]);
    end
  end

  always_comb begin
    for (int k = 0; k < N_ELEM; k++) begin
      logic [3:0] u;
      logic [1:0] st;
      u = usage[k*4 +: 4];
      elemClash[k] = (u[0] & u[2]) | (u[1] & u[3]);
      if (u[0] & u[1])      st = SW_BCAST_UP;
      else if (u[2] & u[3]) st = SW_BCAST_LO;
      else if (u[0] | u[3]) st = SW_STRAIGHT;
      else                  st = SW_CROSS;
      routeCfg[k*2 +: 2] = ((|u) && !elemClash[k]) ? st : curCfg[k*2 +: 2];
    end
    anyClash = |elemClash;
  end

  assign nextCfg         = cfgLoad ? cfgIn : routeCfg;
  assign strobe.cfgWrite = cfgLoad | routeApply;
  assign strobe.rawLoad  = cfgLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           conflictQ <= 1'b0;
    else if (cfgLoad)    conflictQ <= 1'b0;
    else if (routeApply) conflictQ <= anyClash;
  end
  assign conflict = conflictQ;

  // R4
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLoad && !routeApply) |=> $stable(conflictQ));
  // R3
  load_clears_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !conflictQ);
endmodule

// File: rtl/baseline_fabric_dp.sv
module baseline_fabric_dp
  import baseline_fabric_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobe_t                strobe,
  input  logic [CFG_W-1:0]          nextCfg,
  input  logic [N_PORTS-1:0]        inValid,
  input  logic [N_PORTS*DATA_W-1:0] inData,
  output logic [N_PORTS-1:0]        outValid,
  output logic [N_PORTS*DATA_W-1:0] outData,
  output logic [CFG_W-1:0]          cfgQ
);
  localparam int LOG_N  = $clog2(N_PORTS);
  localparam int HALF   = N_PORTS / 2;
  localparam int N_ELEM = HALF * LOG_N;
  localparam int CFG_W  = 2 * N_ELEM;

  logic [DATA_W:0] lvl   [LOG_N+1][N_PORTS];
  logic [DATA_W:0] stOut [LOG_N][N_PORTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgQ <= '0;
    else if (strobe.cfgWrite) cfgQ <= nextCfg;
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_in
    assign lvl[0][p] = {inValid[p], inData[p*DATA_W +: DATA_W]};
    assign outValid[p] = lvl[LOG_N][p][DATA_W];
    assign outData[p*DATA_W +: DATA_W] = lvl[LOG_N][p][DATA_W-1:0];
  end

  for (genvar s = 0; s < LOG_N; s++) begin : g_stage
    for (genvar j = 0; j < HALF; j++) begin : g_el
      baseline_sw2 #(.DATA_W(DATA_W)) u_sw (
        .state (cfgQ[(s*HALF + j)*2 +: 2]),
        .upIn  (lvl[s][2*j]),
        .loIn  (lvl[s][2*j+1]),
        .upOut (stOut[s][2*j]),
        .loOut (stOut[s][2*j+1])
      );
    end
    for (genvar p = 0; p < N_PORTS; p++) begin : g_wire
      localparam int BLK  = N_PORTS >> s;
      localparam int BASE = (p / BLK) * BLK;
      localparam int Q    = p % BLK;
      localparam int DEST = (s == LOG_N-1) ? p : BASE + Q/2 + (Q%2)*(BLK/2);
      assign lvl[s+1][DEST] = stOut[s][p];
    end
  end

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cfgWrite |=> $stable(cfgQ));
  // R3
  raw_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rawLoad |=> cfgQ == $past(nextCfg));
  // R9
  no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid == '0) |-> (outValid == '0));

  for (genvar j = 0; j < HALF; j++) begin : g_bchk
    // R2
    last_bcast_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgQ[((LOG_N-1)*HALF + j)*2 +: 2] inside {SW_BCAST_UP, SW_BCAST_LO})
        |-> (stOut[LOG_N-1][2*j] == stOut[LOG_N-1][2*j+1]));
  end
endmodule

// File: rtl/baseline_fabric.sv
module baseline_fabric
  import baseline_fabric_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 32,
  parameter int N_SLOTS = 8,
  localparam int LOG_N  = $clog2(N_PORTS),
  localparam int CFG_W  = N_PORTS * LOG_N
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgLoad,
  input  logic [CFG_W-1:0]          cfgIn,
  input  logic                      routeApply,
  input  logic [N_SLOTS-1:0]        reqEn,
  input  logic [N_SLOTS*LOG_N-1:0]  reqSrc,
  input  logic [N_SLOTS*LOG_N-1:0]  reqDst,
  input  logic [N_PORTS-1:0]        inValid,
  input  logic [N_PORTS*DATA_W-1:0] inData,
  output logic [N_PORTS-1:0]        outValid,
  output logic [N_PORTS*DATA_W-1:0] outData,
  output logic [CFG_W-1:0]          cfgOut,
  output logic                      conflict
);
  cfgStrobe_t       strobe;
  logic [CFG_W-1:0] nextCfg;

  baseline_route_ctl #(.N_PORTS(N_PORTS), .N_SLOTS(N_SLOTS)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn),
    .routeApply(routeApply), .reqEn(reqEn), .reqSrc(reqSrc), .reqDst(reqDst),
    .curCfg(cfgOut), .strobe(strobe), .nextCfg(nextCfg), .conflict(conflict)
  );

  baseline_fabric_dp #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nextCfg(nextCfg),
    .inValid(inValid), .inData(inData), .outValid(outValid),
    .outData(outData), .cfgQ(cfgOut)
  );

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> cfgOut == $past(cfgIn));
endmodule

// File: tb/baseline_fabric_tb.sv
module baseline_fabric_tb;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int S  = 8;
  localparam int LG = 3;
  localparam int CW = N * LG;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0, routeApply = 1'b0;
  logic [CW-1:0] cfgIn = '0;
  logic [S-1:0] reqEn = '0;
  logic [S*LG-1:0] reqSrc = '0, reqDst = '0;
  logic [N-1:0] inValid = '0;
  logic [N*DW-1:0] inData = '0;
  logic [N-1:0] outValid;
  logic [N*DW-1:0] outData;
  logic [CW-1:0] cfgOut;
  logic conflict;

  int errors = 0, checks = 0;

  baseline_fabric #(.N_PORTS(N), .DATA_W(DW), .N_SLOTS(S)) u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn),
    .routeApply(routeApply), .reqEn(reqEn), .reqSrc(reqSrc), .reqDst(reqDst),
    .inValid(inValid), .inData(inData), .outValid(outValid),
    .outData(outData), .cfgOut(cfgOut), .conflict(conflict)
  );

  always #5 clk = ~clk;

  // single routes (src, dst)
  localparam int VEC [8][2] = '{'{0,7}, '{7,0}, '{3,3}, '{5,2},
                                '{1,6}, '{6,1}, '{4,4}, '{2,5}};

  function automatic int rev(int v);
    return ((v & 1) << 2) | (v & 2) | ((v >> 2) & 1);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fillInputs(logic [31:0] base);
    for (int p = 0; p < N; p++) inData[p*DW +: DW] = base + p;
    inValid = '1;
  endtask

  task automatic clearSlots();
    reqEn = '0; reqSrc = '0; reqDst = '0;
  endtask

  task automatic setSlot(int k, int src, int dst);
    reqEn[k] = 1'b1;
    reqSrc[k*LG +: LG] = LG'(src);
    reqDst[k*LG +: LG] = LG'(dst);
  endtask

  task automatic pulse(logic ld, logic ap);
    cfgLoad = ld; routeApply = ap;
    @(posedge clk);
    @(negedge clk);
    cfgLoad = 1'b0; routeApply = 1'b0;
  endtask

  function automatic logic [31:0] outAt(int p);
    return outData[p*DW +: DW];
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [CW-1:0] expCfg;
    fillInputs(32'hA000_0000);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg", 64'(cfgOut), 64'(0));
    check("R1 conflict", 64'(conflict), 64'(0));
    for (int i = 0; i < N; i++)
      check("R1 bitrev path", 64'(outAt(rev(i))), 64'(32'hA000_0000 + i));

    // R5 single-route table
    for (int v = 0; v < 8; v++) begin
      clearSlots();
      fillInputs(32'hB000_0000 + 32'(v << 8));
      setSlot(0, VEC[v][0], VEC[v][1]);
      pulse(1'b0, 1'b1);
      check("R5 route data", 64'(outAt(VEC[v][1])), 64'(32'hB000_0000 + (v << 8) + VEC[v][0]));
      check("R5 no conflict", 64'(conflict), 64'(0));
    end

    // R9 valid follows its word
    clearSlots();
    setSlot(0, 5, 2);
    pulse(1'b0, 1'b1);
    inValid = 8'hFF & ~(8'h01 << 5);
    #1;
    check("R9 valid low", 64'(outValid[2]), 64'(0));
    inValid = '1;
    #1;
    check("R9 valid high", 64'(outValid[2]), 64'(1));

    // R10 combinational path
    inData[5*DW +: DW] = 32'hC0DE_0005;
    #1;
    check("R10 same-cycle", 64'(outAt(2)), 64'(32'hC0DE_0005));

    // R2 all upper / all lower broadcast
    fillInputs(32'hD000_0000);
    cfgIn = {(CW/2){2'b10}};
    pulse(1'b1, 1'b0);
    for (int p = 0; p < N; p++) check("R2 upper bcast", 64'(outAt(p)), 64'(32'hD000_0000));
    cfgIn = {(CW/2){2'b11}};
    pulse(1'b1, 1'b0);
    for (int p = 0; p < N; p++) check("R2 lower bcast", 64'(outAt(p)), 64'(32'hD000_0007));

    // R7 conflict: 0->0 and 1->1 clash at stage 0 element 0 (all preloaded 11)
    clearSlots();
    setSlot(0, 0, 0);
    setSlot(1, 1, 1);
    pulse(1'b0, 1'b1);
    expCfg = {CW{1'b1}};
    expCfg[9:8]   = 2'b00; // stage1 element0 straight
    expCfg[17:16] = 2'b10; // stage2 element0 upper broadcast
    check("R7 conflict flag", 64'(conflict), 64'(1));
    check("R7 clash elem kept", 64'(cfgOut[1:0]), 64'(2'b11));
    check("R7 cfg merge", 64'(cfgOut), 64'(expCfg));

    // R4 hold with no strobe
    cfgIn = 24'h123456;
    @(negedge clk); @(negedge clk);
    check("R4 cfg hold", 64'(cfgOut), 64'(expCfg));
    check("R4 conflict hold", 64'(conflict), 64'(1));

    // R12 empty apply keeps cfg, clears conflict
    clearSlots();
    pulse(1'b0, 1'b1);
    check("R12 cfg kept", 64'(cfgOut), 64'(expCfg));
    check("R12 conflict clear", 64'(conflict), 64'(0));

    // R8 conflict, then clean apply clears it
    setSlot(0, 0, 0);
    setSlot(1, 1, 1);
    pulse(1'b0, 1'b1);
    check("R8 conflict set", 64'(conflict), 64'(1));
    clearSlots();
    setSlot(0, 3, 4);
    pulse(1'b0, 1'b1);
    check("R8 conflict cleared", 64'(conflict), 64'(0));

    // R3 load wins over apply, clears conflict
    setSlot(1, 0, 0);
    setSlot(2, 1, 1);
    pulse(1'b0, 1'b1);
    cfgIn = 24'h5A5A5A;
    pulse(1'b1, 1'b1);
    check("R3 load wins", 64'(cfgOut), 64'(24'h5A5A5A));
    check("R3 conflict cleared", 64'(conflict), 64'(0));

    // R6 multicast 2 -> 5 and 2 -> 6
    fillInputs(32'hE000_0000);
    clearSlots();
    setSlot(0, 2, 5);
    setSlot(3, 2, 6);
    pulse(1'b0, 1'b1);
    check("R6 out5", 64'(outAt(5)), 64'(32'hE000_0002));
    check("R6 out6", 64'(outAt(6)), 64'(32'hE000_0002));
    check("R6 no conflict", 64'(conflict), 64'(0));

    // R11 whole permutations
    cfgIn = {(CW/2){2'b11}};
    pulse(1'b1, 1'b0);
    clearSlots();
    for (int i = 0; i < N; i++) setSlot(i, i, rev(i));
    pulse(1'b0, 1'b1);
    check("R11 all straight", 64'(cfgOut), 64'(0));
    for (int i = 0; i < N; i++) check("R11 straight path", 64'(outAt(rev(i))), 64'(32'hE000_0000 + i));
    clearSlots();
    for (int i = 0; i < N; i++) setSlot(i, i, rev(i) ^ 7);
    pulse(1'b0, 1'b1);
    check("R11 all cross", 64'(cfgOut), 64'({(CW/2){2'b01}}));
    check("R11 conflict", 64'(conflict), 64'(0));
    for (int i = 0; i < N; i++) check("R11 cross path", 64'(outAt(rev(i) ^ 7)), 64'(32'hE000_0000 + i));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule